// File: doc/BRIEF.md
# Four-Channel Staged Code Loader for a 12-Bit Converter

This block is the digital front end of a four-channel 12-bit converter. A host writes code words into one of four staging registers over a 12-bit data bus. The bus can be used in two ways. A 16-bit host writes a whole code in one cycle. An 8-bit host writes the code left-justified in two cycles: first the upper eight bits, then the lower four bits on the top data lines.

Each staging register has an 8-bit upper part and a 4-bit lower part. A separate commit strobe copies all four staging registers into the four output registers in the same cycle. This lets several channels be prepared first and then change their outputs together.

All strobes are active low. They are sampled on the rising clock edge and act as level enables for every cycle in which they are held low. The reset is synchronous and active high.

Top module: `qdac_front`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all four staging registers and all four outputs to zero.
- R2: A staging register is written only in a cycle where cs_n and wr_load_n are both low. If either is high, no staging register changes.
- R3: ch_addr (0 to 3) selects the one staging register that a write changes. The other three keep their contents.
- R4: With byte_hi high, a write loads the upper part (code bits 11..4) from data_in[11:4] and the lower part (code bits 3..0) from data_in[3:0].
- R5: With byte_hi low, a write loads code bits 3..0 from data_in[11:8] and leaves code bits 11..4 of that channel unchanged.
- R6: In a cycle where xfer_n and wr_commit_n are both low, all four outputs take the contents of their staging registers. The new values are visible after that rising edge.
- R7: In a cycle where xfer_n or wr_commit_n is high, all four outputs keep their values, whatever writes happen.
- R8: When a write and a commit occur in the same cycle, the output takes the staging value from before that cycle's write. The write still lands in the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, qualifies staging writes |
| wr_load_n | input | 1 | Staging write strobe, active low |
| wr_commit_n | input | 1 | Commit gating strobe, active low |
| xfer_n | input | 1 | Commit strobe, active low |
| ch_addr | input | 2 | Channel selected for a staging write |
| byte_hi | input | 1 | 1: full or upper-byte load; 0: lower-nibble load from data_in[11:8] |
| data_in | input | 12 | Host data bus |
| code_out | output | 4x12 | Committed code per channel, packed [3:0][11:0] |

## Verification
The staging write and the global commit can fall in the same cycle. That collision decides whether an output sees the old or the new staging value. The bench provokes it in two ways. It asserts the write and commit strobes together on a channel whose staging value differs from the incoming data. It also does this on the second half of an 8-bit load. In each case it requires the output to show the pre-write code. A later commit alone must then expose the new staging value, which shows that the write was not lost.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int NUM_CH  = 4;
    localparam int CODE_W  = 12;
    localparam int LO_W    = 4;
    localparam int HI_W    = CODE_W - LO_W;
    localparam int ADDR_W  = $clog2(NUM_CH);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [LO_W-1:0]   lo_t;

    typedef struct packed {
        logic              load;
        logic              commit;
        logic              byte_hi;
        logic [ADDR_W-1:0] ch;
    } host_cmd_t;

    typedef struct packed {
        hi_t hi;
        lo_t lo;
    } stage_t;

    function automatic code_t join_code(stage_t s);
        return {s.hi, s.lo};
    endfunction
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic              cs_n,
    input  logic              wr_load_n,
    input  logic              wr_commit_n,
    input  logic              xfer_n,
    input  logic [ADDR_W-1:0] ch_addr,
    input  logic              byte_hi,
    output host_cmd_t         cmd,
    output logic [NUM_CH-1:0] hi_we,
    output logic [NUM_CH-1:0] lo_we
);
    always_comb begin
        cmd.load    = ~cs_n & ~wr_load_n;
        cmd.commit  = ~xfer_n & ~wr_commit_n;
        cmd.byte_hi = byte_hi;
        cmd.ch      = ch_addr;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_en
        logic hit;
        assign hit      = cmd.load && (cmd.ch == ADDR_W'(i));
        assign lo_we[i] = hit;
        assign hi_we[i] = hit && cmd.byte_hi;
    end
endmodule

// File: rtl/qdac_nibble_mux.sv
module qdac_nibble_mux
    import qdac_pkg::*;
(
    input  code_t data_in,
    input  logic  byte_hi,
    output hi_t   hi_bits,
    output lo_t   lo_bits
);
    always_comb begin
        hi_bits = data_in[CODE_W-1:LO_W];
        lo_bits = byte_hi ? data_in[LO_W-1:0] : data_in[CODE_W-1:CODE_W-LO_W];
    end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
    import qdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hi_we,
    input  logic  lo_we,
    input  logic  commit,
    input  hi_t   hi_bits,
    input  lo_t   lo_bits,
    output code_t staged,
    output code_t code
);
    stage_t stage_q;
    code_t  code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            if (hi_we) stage_q.hi <= hi_bits;
            if (lo_we) stage_q.lo <= lo_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (commit) code_q <= join_code(stage_q);
    end

    assign staged = join_code(stage_q);
    assign code   = code_q;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
    import qdac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          wr_load_n,
    input  logic                          wr_commit_n,
    input  logic                          xfer_n,
    input  logic [ADDR_W-1:0]             ch_addr,
    input  logic                          byte_hi,
    input  logic [CODE_W-1:0]             data_in,
    output logic [NUM_CH-1:0][CODE_W-1:0] code_out
);
    host_cmd_t                    cmd;
    logic [NUM_CH-1:0]            hi_we;
    logic [NUM_CH-1:0]            lo_we;
    hi_t                          hi_bits;
    lo_t                          lo_bits;
    logic [NUM_CH-1:0][CODE_W-1:0] staged;

    qdac_decode u_dec (
        .cs_n        (cs_n),
        .wr_load_n   (wr_load_n),
        .wr_commit_n (wr_commit_n),
        .xfer_n      (xfer_n),
        .ch_addr     (ch_addr),
        .byte_hi     (byte_hi),
        .cmd         (cmd),
        .hi_we       (hi_we),
        .lo_we       (lo_we)
    );

    qdac_nibble_mux u_mux (
        .data_in (data_in),
        .byte_hi (cmd.byte_hi),
        .hi_bits (hi_bits),
        .lo_bits (lo_bits)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        qdac_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .hi_we   (hi_we[i]),
            .lo_we   (lo_we[i]),
            .commit  (cmd.commit),
            .hi_bits (hi_bits),
            .lo_bits (lo_bits),
            .staged  (staged[i]),
            .code    (code_out[i])
        );
    end
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk
    import qdac_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          cs_n,
    input logic                          wr_load_n,
    input logic                          wr_commit_n,
    input logic                          xfer_n,
    input logic [ADDR_W-1:0]             ch_addr,
    input logic                          byte_hi,
    input logic [NUM_CH-1:0][CODE_W-1:0] staged,
    input logic [NUM_CH-1:0][CODE_W-1:0] code_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (code_out == '0) && (staged == '0)); // R1

    AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cs_n || wr_load_n) |=> $stable(staged)); // R2

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (!xfer_n && !wr_commit_n) |=> code_out == $past(staged)); // R6

    AST_OUTPUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (xfer_n || wr_commit_n) |=> $stable(code_out)); // R7

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ach
        AST_OTHER_CH_KEEP: assert property (@(posedge clk) disable iff (rst)
            (!cs_n && !wr_load_n && ch_addr != ADDR_W'(i)) |=> $stable(staged[i])); // R3

        AST_HI_KEPT_ON_NIBBLE: assert property (@(posedge clk) disable iff (rst)
            (!cs_n && !wr_load_n && !byte_hi) |=>
                $stable(staged[i][CODE_W-1:LO_W])); // R5
    end
endmodule

bind qdac_front qdac_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .wr_load_n   (wr_load_n),
    .wr_commit_n (wr_commit_n),
    .xfer_n      (xfer_n),
    .ch_addr     (ch_addr),
    .byte_hi     (byte_hi),
    .staged      (staged),
    .code_out    (code_out)
);

// File: tb/qdac_front_test.sv
module qdac_front_test;
    import qdac_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          cs_n, wr_load_n, wr_commit_n, xfer_n, byte_hi;
    logic [ADDR_W-1:0]             ch_addr;
    logic [CODE_W-1:0]             data_in;
    logic [NUM_CH-1:0][CODE_W-1:0] code_out;

    logic [CODE_W-1:0] m_in  [NUM_CH];
    logic [CODE_W-1:0] m_out [NUM_CH];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    qdac_front uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_load_n(wr_load_n),
        .wr_commit_n(wr_commit_n), .xfer_n(xfer_n), .ch_addr(ch_addr),
        .byte_hi(byte_hi), .data_in(data_in), .code_out(code_out)
    );

    task automatic step(input logic r, input logic cs, input logic wl,
                        input logic wc, input logic xf, input int a,
                        input logic bh, input logic [CODE_W-1:0] d);
        @(negedge clk);
        rst = r; cs_n = cs; wr_load_n = wl; wr_commit_n = wc; xfer_n = xf;
        ch_addr = ADDR_W'(a); byte_hi = bh; data_in = d;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NUM_CH; i++) begin m_in[i] = '0; m_out[i] = '0; end
        end else begin
            if (!xf && !wc)
                for (int i = 0; i < NUM_CH; i++) m_out[i] = m_in[i];
            if (!cs && !wl) begin
                if (bh) m_in[a] = d;
                else    m_in[a][LO_W-1:0] = d[CODE_W-1:CODE_W-LO_W];
            end
        end
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1, '0);
    endtask

    task automatic commit();
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b1, '0);
    endtask

    task automatic check_outs(input string req);
        for (int i = 0; i < NUM_CH; i++) begin
            n_chk++;
            if (code_out[i] !== m_out[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d actual %03h expected %03h", req, i, code_out[i], m_out[i]);
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; wr_load_n = 1'b1; wr_commit_n = 1'b1;
        xfer_n = 1'b1; ch_addr = '0; byte_hi = 1'b1; data_in = '0;
        for (int i = 0; i < NUM_CH; i++) begin m_in[i] = '0; m_out[i] = '0; end
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1, 12'hFFF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1, 12'hFFF);
        check_outs("R1 reset");

        // R4 R3 R6 R7: one-cycle loads on every channel, sweep of patterns
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int k = 0; k < 16; k++) begin
                logic [CODE_W-1:0] v;
                v = CODE_W'((ch * 12'h3A5 + k * 12'h111 + k * k * 7) & 12'hFFF);
                step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ch, 1'b1, v);
                check_outs("R7 before commit");
                commit();
                check_outs("R4 R3 R6 full load");
            end
        end

        // R5: two-cycle byte-wide loads
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int k = 0; k < 8; k++) begin
                logic [HI_W-1:0] hb;
                logic [LO_W-1:0] lb;
                hb = HI_W'(ch * 37 + k * 29 + 5);
                lb = LO_W'(k * 3 + ch);
                step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ch, 1'b1, {hb, 4'hA});
                step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ch, 1'b0, {lb, 8'h5C});
                check_outs("R7 between halves");
                commit();
                check_outs("R5 two-cycle load");
                n_chk++;
                if (code_out[ch] !== {hb, lb}) begin
                    n_bad++;
                    $display("FAIL R5 ch%0d actual %03h expected %03h", ch, code_out[ch], {hb, lb});
                end
            end
        end

        // R6: stage all channels, one commit updates them together
        for (int ch = 0; ch < NUM_CH; ch++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ch, 1'b1, CODE_W'(12'hC0D + ch * 12'h222));
            check_outs("R7 staging all");
        end
        commit();
        check_outs("R6 simultaneous commit");

        // R2: writes without both strobes low are ignored
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, 12'h123);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b1, 12'h456);
        commit();
        check_outs("R2 gated write");

        // R6 R7: only one of the commit strobes low
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3, 1'b1, 12'h9E1);
        check_outs("R7 xfer alone");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b1, 12'h000);
        check_outs("R7 wr_commit alone");
        commit();
        check_outs("R6 after partial strobes");

        // R8: write and commit in the same cycle
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 12'h7B3);
        check_outs("R8 collision full");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 12'h200);
        check_outs("R8 collision nibble");
        commit();
        check_outs("R8 write landed");
        n_chk++;
        if (code_out[0] !== 12'h7B2) begin
            n_bad++;
            $display("FAIL R8 ch0 actual %03h expected 7b2", code_out[0]);
        end

        // R7: held strobe commits every cycle; idle keeps values
        idle();
        check_outs("R7 idle");

        // R1: reset mid-run
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 12'hFFF);
        check_outs("R1 mid-run reset");
        commit();
        check_outs("R1 staging cleared");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule